// File: doc/BRIEF.md
# Regulator Fault and Power-Good Supervisor

This block supervises a switching regulator controller from digitized comparator results. It watches the feedback comparators for over-voltage, under-voltage, the power-good low threshold and the power-good recovery threshold, together with the enable pin and a supply-good flag from the UVLO circuit. From these it decides whether the controller runs, whether a shutdown fault is latched, and when the power-good output may go high.

There are two latched faults, each with its own consecutive-cycle qualifier. A qualified over-voltage asks the driver to hold the low-side switch on. A qualified under-voltage asks the driver to tri-state both switches. A fault stays latched until enable goes low or the supply drops below the UVLO threshold. Either of these returns the block to its off state, which clears both latches, so that the next start begins clean. Power-good waits for a start-up delay, counted from enable, and for soft-start completion. It then follows the feedback window with hysteresis.

Top module: `reg_fault_supervisor`

## Requirements
- R1: Out of reset, and in the cycle after enable or supply-good is sampled low, run_o=0, force_ls_o=0, tristate_o=1 and pgood_o=0.
- R2: With en_i=1 and supply_ok_i=1, run_o rises at the first clock edge that samples both high.
- R3: When ov_cmp_i is sampled high on OV_CYCLES consecutive edges during run, force_ls_o=1 from that last edge on, with run_o=0, tristate_o=0 and pgood_o=0.
- R4: An over-voltage run shorter than OV_CYCLES edges, broken by one low sample, leaves run_o=1 and restarts the count.
- R5: When uv_cmp_i is sampled high on UV_CYCLES consecutive edges during run, tristate_o=1 and run_o=0 from that last edge on.
- R6: Any low sample of uv_cmp_i restarts the under-voltage count, so that two runs of UV_CYCLES-1 edges each leave run_o=1.
- R7: A latched fault holds after its comparator clears. It ends only when enable is sampled low, and the next enable starts a new run.
- R8: If both faults qualify on the same edge, the over-voltage fault is latched (force_ls_o=1, tristate_o=0).
- R9: pgood_o stays 0 until PG_DLY_CYCLES edges have sampled enable and supply-good high since they last went low, and stays 0 while ss_done_i=0.
- R10: pgood_o drops when pg_low_cmp_i is sampled high. It returns only after pg_rec_cmp_i is sampled high with pg_low_cmp_i low.
- R11: pgood_o is 0 in any cycle in which ov_cmp_i is high, before any qualification.
- R12: A low supply_ok_i tri-states the drives, clears any latched fault and restarts the start-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Controller enable |
| supply_ok_i | input | 1 | Supply above UVLO threshold |
| ov_cmp_i | input | 1 | Feedback above over-voltage threshold |
| uv_cmp_i | input | 1 | Feedback below under-voltage threshold |
| pg_low_cmp_i | input | 1 | Feedback below power-good low threshold |
| pg_rec_cmp_i | input | 1 | Feedback above power-good recovery threshold |
| ss_done_i | input | 1 | Soft-start ramp complete |
| run_o | output | 1 | Controller may switch |
| force_ls_o | output | 1 | Hold low-side switch on (over-voltage latch) |
| tristate_o | output | 1 | Turn both switches off |
| pgood_o | output | 1 | Power-good indication |

## Verification
Comparator bursts that stop one edge short of the qualifying length are run against full-length bursts. This separates an off-by-one qualifier from a correct one and shows that a single low sample restarts the count. Under-voltage and over-voltage are started three cycles apart, so that both qualify on the same edge; this tells a correct priority from a reversed one. The power-good sequence sweeps every edge of the start-up delay, with soft-start withheld at the delay's end. It then steps the feedback through low, in-band and recovered levels. This separates the delay gate, the soft-start gate and the hysteresis.

// File: rtl/reg_sup_pkg.sv
package reg_sup_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_RUN    = 2'd1,
    ST_OV_FLT = 2'd2,
    ST_UV_FLT = 2'd3
  } sup_state_e;
endpackage

// File: rtl/sup_qual_filter.sv
module sup_qual_filter #(
  parameter int unsigned N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cmp_i,
  output logic trip_o
);
  localparam int unsigned W = (N < 2) ? 1 : $clog2(N);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (!cmp_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // trips on the Nth consecutive high sample
  assign trip_o = cmp_i && (cnt_q == LAST);

  // R4 / R6: a trip needs the comparator high on the previous edge as well
  p_trip_needs_history_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !clr_i && (N > 1)) |-> $past(cmp_i));
endmodule

// File: rtl/sup_startup_timer.sv
module sup_startup_timer #(
  parameter int unsigned DLY = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(DLY + 1);
  localparam logic [W-1:0] END_CNT = W'(DLY);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != END_CNT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == END_CNT);

  // R9: once elapsed, the delay stays elapsed until cleared
  p_done_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);
endmodule

// File: rtl/sup_pg_hyst.sv
module sup_pg_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic low_i,
  input  logic rec_i,
  output logic ok_o
);
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ok_q <= 1'b0;
    else if (!active_i) ok_q <= 1'b0;
    else if (low_i)     ok_q <= 1'b0;
    else if (rec_i)     ok_q <= 1'b1;
  end

  assign ok_o = ok_q;

  // R10: low threshold wins; in-band feedback keeps the prior decision
  p_low_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && low_i) |=> !ok_o);
  p_inband_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !low_i && !rec_i) |=> $stable(ok_o));
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
  import reg_sup_pkg::*;
#(
  parameter int unsigned OV_CYCLES     = 500,
  parameter int unsigned UV_CYCLES     = 8,
  parameter int unsigned PG_DLY_CYCLES = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic supply_ok_i,
  input  logic ov_cmp_i,
  input  logic uv_cmp_i,
  input  logic pg_low_cmp_i,
  input  logic pg_rec_cmp_i,
  input  logic ss_done_i,
  output logic run_o,
  output logic force_ls_o,
  output logic tristate_o,
  output logic pgood_o
);
  sup_state_e state_q, state_d;
  logic active, ov_trip, uv_trip, dly_done, pg_ok;

  assign active = en_i && supply_ok_i;

  sup_qual_filter #(.N(OV_CYCLES)) u_ov_filt (
    .clk_i, .rst_ni, .clr_i(!active), .cmp_i(ov_cmp_i), .trip_o(ov_trip)
  );

  sup_qual_filter #(.N(UV_CYCLES)) u_uv_filt (
    .clk_i, .rst_ni, .clr_i(!active), .cmp_i(uv_cmp_i), .trip_o(uv_trip)
  );

  sup_startup_timer #(.DLY(PG_DLY_CYCLES)) u_dly (
    .clk_i, .rst_ni, .clr_i(!active), .done_o(dly_done)
  );

  sup_pg_hyst u_pg (
    .clk_i, .rst_ni, .active_i(active), .low_i(pg_low_cmp_i),
    .rec_i(pg_rec_cmp_i), .ok_o(pg_ok)
  );

  always_comb begin
    state_d = state_q;
    if (!active) begin
      state_d = ST_OFF;  // enable toggle or POR clears latches
    end else begin
      unique case (state_q)
        ST_OFF: state_d = ST_RUN;
        ST_RUN: begin
          if (ov_trip)      state_d = ST_OV_FLT;  // over-voltage has priority
          else if (uv_trip) state_d = ST_UV_FLT;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign run_o      = (state_q == ST_RUN);
  assign force_ls_o = (state_q == ST_OV_FLT);
  assign tristate_o = (state_q == ST_OFF) || (state_q == ST_UV_FLT);
  assign pgood_o    = run_o && dly_done && ss_done_i && pg_ok && !ov_cmp_i;

  p_off_after_inactive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (tristate_o && !pgood_o && !force_ls_o));
  p_ov_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_ls_o && active) |=> force_ls_o);
  p_uv_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tristate_o && !run_o && state_q == ST_UV_FLT && active) |=> (tristate_o && !force_ls_o));
  p_ov_priority_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && active && ov_trip && uv_trip) |=> force_ls_o);
  p_pgood_ov_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_cmp_i |-> !pgood_o);
endmodule

// File: tb/sim_reg_fault_supervisor.sv
module sim_reg_fault_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int OV_N  = 5;
  localparam int UV_N  = 8;
  localparam int DLY_N = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, supply_ok_i = 1'b1, ov_cmp_i = 1'b0, uv_cmp_i = 1'b0;
  logic pg_low_cmp_i = 1'b0, pg_rec_cmp_i = 1'b0, ss_done_i = 1'b0;
  logic run_o, force_ls_o, tristate_o, pgood_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    string      tag;
    logic [3:0] exp;  // {run, force_ls, tristate, pgood}
  } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_fault_supervisor #(
    .OV_CYCLES(OV_N), .UV_CYCLES(UV_N), .PG_DLY_CYCLES(DLY_N)
  ) u0 (
    .clk_i(clk), .rst_ni, .en_i, .supply_ok_i, .ov_cmp_i, .uv_cmp_i,
    .pg_low_cmp_i, .pg_rec_cmp_i, .ss_done_i,
    .run_o, .force_ls_o, .tristate_o, .pgood_o
  );

  // driver: wait one edge, then queue the outputs expected after it
  task automatic expect_edge(string tag, logic r, logic f, logic t, logic p);
    item_t it;
    @(posedge clk);
    it.tag = tag;
    it.exp = {r, f, t, p};
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it  = exp_q.pop_front();
      act = {run_o, force_ls_o, tristate_o, pgood_o};
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: {run,force,tri,pg} actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    expect_edge("R1 reset state", 0, 0, 1, 0);

    // R2: start
    en_i = 1'b1; pg_rec_cmp_i = 1'b1;
    expect_edge("R2 run on enable", 1, 0, 0, 0);
    // R9: delay gate, edges 2..DLY_N-1 since enable
    for (int k = 2; k < DLY_N; k++) expect_edge("R9 delay not elapsed", 1, 0, 0, 0);
    expect_edge("R9 soft-start not done", 1, 0, 0, 0);
    ss_done_i = 1'b1;
    expect_edge("R9 pgood after delay and soft-start", 1, 0, 0, 1);

    // R10: hysteresis
    pg_rec_cmp_i = 1'b0; pg_low_cmp_i = 1'b1;
    expect_edge("R10 pgood low threshold", 1, 0, 0, 0);
    pg_low_cmp_i = 1'b0;
    expect_edge("R10 in-band stays low", 1, 0, 0, 0);
    expect_edge("R10 in-band stays low", 1, 0, 0, 0);
    pg_rec_cmp_i = 1'b1;
    expect_edge("R10 recovered", 1, 0, 0, 1);

    // R11: raw over-voltage masks pgood at once
    ov_cmp_i = 1'b1;
    #1;
    n_tests++;
    if (pgood_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: pgood actual %b expected 0", pgood_o);
    end
    expect_edge("R11 pgood masked by ov", 1, 0, 0, 0);
    ov_cmp_i = 1'b0;
    expect_edge("R11 pgood back", 1, 0, 0, 1);

    // R4: short bursts with one-sample break
    ov_cmp_i = 1'b1;
    for (int k = 0; k < OV_N - 1; k++) expect_edge("R4 short ov burst", 1, 0, 0, 0);
    ov_cmp_i = 1'b0;
    expect_edge("R4 ov break", 1, 0, 0, 1);
    ov_cmp_i = 1'b1;
    for (int k = 0; k < OV_N - 1; k++) expect_edge("R4 second short ov burst", 1, 0, 0, 0);
    ov_cmp_i = 1'b0;
    expect_edge("R4 still running", 1, 0, 0, 1);

    // R6: under-voltage count restarts
    uv_cmp_i = 1'b1;
    for (int k = 0; k < UV_N - 1; k++) expect_edge("R6 short uv burst", 1, 0, 0, 1);
    uv_cmp_i = 1'b0;
    expect_edge("R6 uv break", 1, 0, 0, 1);
    uv_cmp_i = 1'b1;
    for (int k = 0; k < UV_N - 1; k++) expect_edge("R6 second short uv burst", 1, 0, 0, 1);
    uv_cmp_i = 1'b0;
    expect_edge("R6 still running", 1, 0, 0, 1);

    // R3: qualified over-voltage
    ov_cmp_i = 1'b1;
    for (int k = 0; k < OV_N - 1; k++) expect_edge("R3 ov qualifying", 1, 0, 0, 0);
    expect_edge("R3 ov latched", 0, 1, 0, 0);
    ov_cmp_i = 1'b0;
    for (int k = 0; k < 3; k++) expect_edge("R7 ov stays latched", 0, 1, 0, 0);

    // R7: enable toggle clears and restarts
    en_i = 1'b0;
    expect_edge("R7 enable low clears", 0, 0, 1, 0);
    en_i = 1'b1;
    expect_edge("R7 restart after toggle", 1, 0, 0, 0);

    // R5: qualified under-voltage
    uv_cmp_i = 1'b1;
    for (int k = 0; k < UV_N - 1; k++) expect_edge("R5 uv qualifying", 1, 0, 0, 0);
    expect_edge("R5 uv latched", 0, 0, 1, 0);
    uv_cmp_i = 1'b0;
    for (int k = 0; k < 3; k++) expect_edge("R7 uv stays latched", 0, 0, 1, 0);

    // R12: supply drop clears latch, restarts delay
    supply_ok_i = 1'b0;
    expect_edge("R12 supply low tri-state", 0, 0, 1, 0);
    supply_ok_i = 1'b1;
    expect_edge("R12 restart after POR", 1, 0, 0, 0);
    for (int k = 2; k < DLY_N; k++) expect_edge("R12 delay restarted", 1, 0, 0, 0);
    expect_edge("R12 pgood after new delay", 1, 0, 0, 1);

    // R8: both faults qualify on the same edge
    uv_cmp_i = 1'b1;
    for (int k = 0; k < UV_N - OV_N; k++) expect_edge("R8 uv lead", 1, 0, 0, 1);
    ov_cmp_i = 1'b1;
    for (int k = 0; k < OV_N - 1; k++) expect_edge("R8 both pending", 1, 0, 0, 0);
    expect_edge("R8 ov wins", 0, 1, 0, 0);
    ov_cmp_i = 1'b0; uv_cmp_i = 1'b0;
    expect_edge("R8 ov held", 0, 1, 0, 0);

    @(posedge clk);
    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule